// File: doc/BRIEF.md
# Multi-Channel Receive FIFO Controller

This block merges data words from a set of input channels into one shared receive queue. A processor drains the queue and controls the block over a small word-addressed register bus. Each channel offers a word with a valid strobe and gets no back-pressure. The block accepts a word only when the channel's own enable and a global enable are both on. When several channels offer in the same cycle, fixed priority picks one word. Words the block cannot take are dropped. A dropped word sets that channel's sticky overflow flag if the queue was full.

There are four register addresses: control A at 0, control B at 1, status at 2 and the queue data port at 3. A read of the data port while the queue is empty holds the bus ready signal low until a word arrives. A hang-disable control bit turns that stall off. With hang disable set, the empty read completes at once and returns the last word read.

Top module: `chan_rx_fifo`

## Requirements
- R1: A channel word enters the queue only when control A bit 7 (global enable) and the channel's bit in control B bits [NUM_CH-1:0] are both 1. Otherwise the word is dropped and the fill count is not raised.
- R2: At most one word is accepted per clock. Among the eligible channels, the lowest-numbered one wins. Words leave the data port (address 3) in the order they were accepted.
- R3: Status bits 31:28 hold the number of queued words, which never exceeds DEPTH (8). An accepted push and a completed data-port read in the same cycle leave the count unchanged.
- R4: Writing control B with bit 31 set empties the queue. A push in that same cycle is discarded. Bit 31 always reads back as 0, while bits [NUM_CH-1:0] read back the channel enables.
- R5: A write to control A that takes bit 7 from 1 to 0 empties the queue.
- R6: Status bit c (c < NUM_CH) is set when channel c is eligible in a cycle where the queue is full and its word is not accepted.
- R7: The overflow flags stay set across flushes. Only writing control A with bit 6 set clears them, and bit 6 reads back as 0. A flag set in the same cycle as a clear ends up set.
- R8: With control A bit 4 (hang disable) at 0, a data-port read of an empty queue holds bus_ready low. The read completes, with the word, in the cycle after a word is accepted.
- R9: With hang disable at 1, a data-port read of an empty queue completes at once. It returns the last word read (0 after reset) and leaves the count at 0.
- R10: After reset, control A, control B and status read 0, and bus_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_valid | input | NUM_CH | Per-channel word strobe |
| ch_data | input | NUM_CH*DATA_W | Channel words, channel c at bits [c*DATA_W +: DATA_W] |
| bus_sel | input | 1 | Bus transfer request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address (0 control A, 1 control B, 2 status, 3 data) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ready is 1 |
| bus_ready | output | 1 | Transfer completes in a cycle where this is 1 |

## Verification
The hardest situations to reach are a full queue that is pushed and popped in the same cycle while other channels are eligible, and a stalled empty read that a channel word releases. The bench reaches both with directed sequences. It fills the queue to exactly eight words, then reads the data port while several channels strobe at once. It also holds a data-port read on an empty queue for several cycles before strobing a single channel. Seeded random traffic with rare flushes and enable drops then mixes these events in every order.

// File: rtl/chan_rx_pkg.sv
package chan_rx_pkg;
   localparam int BUS_W      = 32;
   localparam int ADDR_W     = 2;
   localparam int C0_GEN_BIT = 7;
   localparam int C0_CLR_BIT = 6;
   localparam int C0_HD_BIT  = 4;
   localparam int C1_FLUSH   = 31;
   localparam int ST_CNT_LSB = 28;

   typedef enum logic [ADDR_W-1:0] {
      REG_CTRLA = 2'd0,
      REG_CTRLB = 2'd1,
      REG_STAT  = 2'd2,
      REG_DATA  = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/chan_rx_arb.sv
module chan_rx_arb #(
   parameter int NUM_CH = 8,
   parameter int DATA_W = 32
) (
   input  logic [NUM_CH-1:0]        req,
   input  logic [NUM_CH*DATA_W-1:0] data_flat,
   output logic                     any,
   output logic [NUM_CH-1:0]        gnt,
   output logic [DATA_W-1:0]        gnt_data
);
   logic [NUM_CH:0] lower;

   assign lower[0] = 1'b0;
   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_pri
         assign gnt[c]     = req[c] & ~lower[c];
         assign lower[c+1] = lower[c] | req[c];
      end
   endgenerate

   assign any = lower[NUM_CH];

   always_comb begin
      gnt_data = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         gnt_data = gnt_data | (data_flat[c*DATA_W +: DATA_W] & {DATA_W{gnt[c]}});
      end
   end
endmodule

// File: rtl/chan_rx_store.sv
module chan_rx_store #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 8,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] head,
   output logic [CNT_W-1:0]  count,
   output logic              full,
   output logic              empty
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_nxt, rd_nxt;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   assign head  = mem[rd_ptr];
   assign full  = (count == CNT_W'(DEPTH));
   assign empty = (count == '0);

   always_ff @(posedge clk) begin
      if (push && !flush) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/chan_rx_regs.sv
module chan_rx_regs
   import chan_rx_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              bus_ready,
   input  logic [CNT_W-1:0]  fill_cnt,
   input  logic              empty,
   input  logic [DATA_W-1:0] head,
   input  logic [NUM_CH-1:0] ovf_set,
   output logic              glob_en,
   output logic              hang_dis,
   output logic [NUM_CH-1:0] ch_en,
   output logic              flush,
   output logic              pop,
   output logic [NUM_CH-1:0] ovf_flags
);
   logic              wr_a, wr_b, rd_data, ovf_clr;
   logic [DATA_W-1:0] last_rd_q;
   reg_sel_e          sel_reg;

   assign sel_reg = reg_sel_e'(bus_addr);
   assign wr_a    = bus_sel &  bus_wr & (sel_reg == REG_CTRLA);
   assign wr_b    = bus_sel &  bus_wr & (sel_reg == REG_CTRLB);
   assign rd_data = bus_sel & ~bus_wr & (sel_reg == REG_DATA);

   assign bus_ready = ~(rd_data & empty & ~hang_dis);
   assign pop       = rd_data & ~empty;
   assign ovf_clr   = wr_a & bus_wdata[C0_CLR_BIT];
   assign flush     = (wr_b & bus_wdata[C1_FLUSH]) |
                      (wr_a & glob_en & ~bus_wdata[C0_GEN_BIT]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glob_en   <= 1'b0;
         hang_dis  <= 1'b0;
         ch_en     <= '0;
         ovf_flags <= '0;
         last_rd_q <= '0;
      end else begin
         if (wr_a) begin
            glob_en  <= bus_wdata[C0_GEN_BIT];
            hang_dis <= bus_wdata[C0_HD_BIT];
         end
         if (wr_b) ch_en <= bus_wdata[NUM_CH-1:0];
         ovf_flags <= (ovf_clr ? '0 : ovf_flags) | ovf_set;
         if (pop) last_rd_q <= head;
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (sel_reg)
         REG_CTRLA: begin
            bus_rdata[C0_GEN_BIT] = glob_en;
            bus_rdata[C0_HD_BIT]  = hang_dis;
         end
         REG_CTRLB: bus_rdata[NUM_CH-1:0] = ch_en;
         REG_STAT: begin
            bus_rdata[ST_CNT_LSB +: CNT_W] = fill_cnt;
            bus_rdata[NUM_CH-1:0]          = ovf_flags;
         end
         REG_DATA: bus_rdata[DATA_W-1:0] = empty ? last_rd_q : head;
         default:  bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/chan_rx_fifo.sv
module chan_rx_fifo
   import chan_rx_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int DATA_W = 32,
   parameter int DEPTH  = 8,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_CH-1:0]        ch_valid,
   input  logic [NUM_CH*DATA_W-1:0] ch_data,
   input  logic                     bus_sel,
   input  logic                     bus_wr,
   input  logic [1:0]               bus_addr,
   input  logic [31:0]              bus_wdata,
   output logic [31:0]              bus_rdata,
   output logic                     bus_ready
);
   generate
      if (NUM_CH < 1 || NUM_CH > ST_CNT_LSB) begin : g_bad_ch
         $error("NUM_CH must be 1..28");
      end
      if (DEPTH < 2 || ST_CNT_LSB + CNT_W > BUS_W) begin : g_bad_depth
         $error("DEPTH must be 2..15");
      end
      if (DATA_W < 1 || DATA_W > BUS_W) begin : g_bad_width
         $error("DATA_W must be 1..32");
      end
   endgenerate

   logic              glob_en, hang_dis, flush, pop, accept;
   logic              any_req, fifo_full, fifo_empty;
   logic [NUM_CH-1:0] ch_en, eligible, gnt, ovf_set, ovf_flags;
   logic [DATA_W-1:0] gnt_data, head;
   logic [CNT_W-1:0]  fill_cnt;

   assign eligible = ch_valid & ch_en & {NUM_CH{glob_en}};
   assign accept   = any_req & ~flush & (~fifo_full | pop);
   assign ovf_set  = eligible & ~(gnt & {NUM_CH{accept}}) & {NUM_CH{fifo_full}};

   chan_rx_arb #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_arb (
      .req(eligible), .data_flat(ch_data), .any(any_req),
      .gnt(gnt), .gnt_data(gnt_data)
   );

   chan_rx_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .flush(flush), .push(accept),
      .push_data(gnt_data), .pop(pop), .head(head), .count(fill_cnt),
      .full(fifo_full), .empty(fifo_empty)
   );

   chan_rx_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_ready(bus_ready), .fill_cnt(fill_cnt), .empty(fifo_empty),
      .head(head), .ovf_set(ovf_set), .glob_en(glob_en), .hang_dis(hang_dis),
      .ch_en(ch_en), .flush(flush), .pop(pop), .ovf_flags(ovf_flags)
   );
endmodule

// File: rtl/chan_rx_checker.sv
module chan_rx_checker #(
   parameter int NUM_CH = 8,
   parameter int DEPTH  = 8,
   parameter int CNT_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [1:0]        bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              bus_ready,
   input logic              glob_en,
   input logic              hang_dis,
   input logic              fifo_empty,
   input logic [CNT_W-1:0]  fill_cnt,
   input logic [NUM_CH-1:0] ovf_flags
);
   logic rd_data, wr_a, wr_b;
   assign rd_data = bus_sel && !bus_wr && bus_addr == 2'd3;
   assign wr_a    = bus_sel && bus_wr && bus_addr == 2'd0;
   assign wr_b    = bus_sel && bus_wr && bus_addr == 2'd1;

   assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fill_cnt <= CNT_W'(DEPTH));

   assert_no_fill_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !glob_en |=> fill_cnt <= $past(fill_cnt));

   assert_flush_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_b && bus_wdata[31]) |=> fill_cnt == '0);

   assert_enable_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_a && glob_en && !bus_wdata[7]) |=> fill_cnt == '0);

   assert_flags_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_a && bus_wdata[6]) |=> (ovf_flags & $past(ovf_flags)) == $past(ovf_flags));

   assert_stall_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && fifo_empty && !hang_dis) |-> !bus_ready);

   assert_no_hang_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && hang_dis) |-> bus_ready);
endmodule

bind chan_rx_fifo chan_rx_checker #(.NUM_CH(NUM_CH), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
   .glob_en(glob_en), .hang_dis(hang_dis), .fifo_empty(fifo_empty),
   .fill_cnt(fill_cnt), .ovf_flags(ovf_flags)
);

// File: tb/chan_rx_fifo_bench.sv
module chan_rx_fifo_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [7:0]   ch_valid = '0;
   logic [255:0] ch_data = '0;
   logic         bus_sel = 1'b0, bus_wr = 1'b0;
   logic [1:0]   bus_addr = '0;
   logic [31:0]  bus_wdata = '0;
   logic [31:0]  bus_rdata;
   logic         bus_ready;

   int n_vec = 0, n_fail = 0, wd_cnt = 0;
   logic [31:0] m_q[$];
   logic [31:0] m_last = '0;
   logic [7:0]  m_chen = '0, m_ovf = '0;
   bit          m_en = 0, m_hd = 0;

   always #4 clk = ~clk;

   chan_rx_fifo u_chan_rx_fifo (
      .clk(clk), .rst_n(rst_n), .ch_valid(ch_valid), .ch_data(ch_data),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready)
   );

   always @(posedge clk) begin
      wd_cnt++;
      if (wd_cnt == 150000) begin
         n_fail++;
         $display("FAIL watchdog: run not finished (actual=hung expected=done)");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

   function automatic logic [31:0] exp_rdata(input logic [1:0] a);
      logic [31:0] r = '0;
      case (a)
         2'd0: begin r[7] = m_en; r[4] = m_hd; end
         2'd1: r[7:0] = m_chen;
         2'd2: begin r[31:28] = 4'(m_q.size()); r[7:0] = m_ovf; end
         default: r = (m_q.size() != 0) ? m_q[0] : m_last;
      endcase
      return r;
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic cyc(input string tag, input bit sel, input bit wr,
                      input logic [1:0] addr, input logic [31:0] wd,
                      input logic [7:0] vmask, output bit rdy);
      logic [7:0] elig, ovfset;
      bit full, flush, pop, acc, wra, wrb, exp_rdy;
      int win;
      @(negedge clk);
      bus_sel = sel; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
      ch_valid = vmask;
      for (int c = 0; c < 8; c++) ch_data[c*32 +: 32] = $urandom;
      #1;
      exp_rdy = !(sel && !wr && addr == 2'd3 && m_q.size() == 0 && !m_hd);
      if (sel && !wr) begin
         check(tag, "bus_ready", 32'(bus_ready), 32'(exp_rdy));
         if (exp_rdy) check(tag, "bus_rdata", bus_rdata, exp_rdata(addr));
      end
      elig  = vmask & m_chen & {8{m_en}};
      full  = (m_q.size() == 8);
      wra   = sel && wr && addr == 2'd0;
      wrb   = sel && wr && addr == 2'd1;
      flush = (wrb && wd[31]) || (wra && m_en && !wd[7]);
      pop   = sel && !wr && addr == 2'd3 && m_q.size() > 0;
      win   = -1;
      for (int c = 0; c < 8; c++) if (elig[c] && win < 0) win = c;
      acc    = (win >= 0) && !flush && (!full || pop);
      ovfset = full ? elig : 8'h00;
      if (acc) ovfset[win] = 1'b0;
      if (pop) m_last = m_q.pop_front();
      if (flush) m_q.delete();
      if (acc) m_q.push_back(ch_data[win*32 +: 32]);
      if (wra && wd[6]) m_ovf = '0;
      m_ovf = m_ovf | ovfset;
      if (wra) begin m_en = wd[7]; m_hd = wd[4]; end
      if (wrb) m_chen = wd[7:0];
      rdy = exp_rdy;
   endtask

   task automatic wr(input string tag, input logic [1:0] a, input logic [31:0] d,
                     input logic [7:0] v = 8'h00);
      bit r;
      cyc(tag, 1, 1, a, d, v, r);
   endtask

   task automatic rd(input string tag, input logic [1:0] a, input logic [7:0] v = 8'h00);
      bit r;
      cyc(tag, 1, 0, a, 32'h0, v, r);
   endtask

   task automatic push(input string tag, input logic [7:0] v);
      bit r;
      cyc(tag, 0, 0, 2'd0, 32'h0, v, r);
   endtask

   initial begin
      bit r;
      void'($urandom(32'h2468ACE1));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1 check("R10", "idle bus_ready", 32'(bus_ready), 32'd1);
      rd("R10", 2'd0); rd("R10", 2'd1); rd("R10", 2'd2);

      // R1: either enable alone drops words
      wr("R1", 2'd0, 32'h80); push("R1", 8'h01); rd("R1", 2'd2);
      wr("R1", 2'd0, 32'h00); wr("R1", 2'd1, 32'h01); push("R1", 8'h01); rd("R1", 2'd2);
      wr("R1", 2'd0, 32'h80); push("R1", 8'h03); rd("R1", 2'd2); rd("R1", 2'd3);

      // R2: lowest channel wins, order kept
      wr("R2", 2'd1, 32'hFF);
      push("R2", 8'h06); push("R2", 8'hA0); push("R2", 8'h80);
      rd("R2", 2'd3); rd("R2", 2'd3); rd("R2", 2'd3); rd("R2", 2'd2);

      // R3 / R6: fill, push+pop when full, overflow flags
      for (int i = 0; i < 8; i++) push("R3", 8'h01 << (i % 8));
      rd("R3", 2'd2);
      rd("R3", 2'd3, 8'h24); rd("R3", 2'd2);
      push("R6", 8'h24); rd("R6", 2'd2);

      // R4: flush wins over push, bit 31 reads 0; R7 flags survive
      wr("R4", 2'd1, 32'h8000_00FF, 8'h01); rd("R4", 2'd2); rd("R4", 2'd1);
      rd("R7", 2'd2);
      wr("R7", 2'd0, 32'hC0, 8'h00); rd("R7", 2'd0); rd("R7", 2'd2);
      for (int i = 0; i < 8; i++) push("R7", 8'h01);
      wr("R7", 2'd0, 32'hC0, 8'h08); rd("R7", 2'd2);
      wr("R7", 2'd0, 32'hC0); rd("R7", 2'd2);

      // R5: enable drop flushes
      wr("R5", 2'd1, 32'h8000_00FF);
      push("R5", 8'h10); push("R5", 8'h20); push("R5", 8'h40);
      wr("R5", 2'd0, 32'h00); rd("R5", 2'd2);

      // R8: stall until a word arrives
      wr("R8", 2'd0, 32'h80);
      cyc("R8", 1, 0, 2'd3, 0, 8'h00, r);
      cyc("R8", 1, 0, 2'd3, 0, 8'h00, r);
      cyc("R8", 1, 0, 2'd3, 0, 8'h08, r);
      cyc("R8", 1, 0, 2'd3, 0, 8'h00, r);
      check("R8", "read released", 32'(r), 32'd1);

      // R9: hang disabled, returns last word read
      wr("R9", 2'd0, 32'h90); rd("R9", 2'd3); rd("R9", 2'd2);

      // random mix
      for (int i = 0; i < 3000; i++) begin
         int k = $urandom_range(0, 15);
         logic [7:0] v = (($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom));
         logic [31:0] d = $urandom;
         if (k == 0) begin
            d[7] = ($urandom_range(0, 9) != 0);
            d[6] = ($urandom_range(0, 3) == 0);
            wr("R7", 2'd0, d, v);
         end else if (k == 1) begin
            d[31] = ($urandom_range(0, 7) == 0);
            d[7:0] = d[7:0] | 8'h11;
            wr("R4", 2'd1, d, v);
         end else if (k < 6) rd("R3", 2'($urandom_range(0, 2)), v);
         else if (k < 10) rd("R2", 2'd3, v);
         else push("R6", v);
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end
endmodule